// File: doc/BRIEF.md
# Shift and Rotate-with-Mask Unit

This block is the combinational datapath of a 64-bit integer shift unit in a processor execution stage. Each operation arrives with a source operand, a shift amount, a merge operand and a short operation record: an opcode, a 32-bit mode flag, a signed flag, two mask position immediates, an opaque context word and a mux id. In the same cycle the unit returns the result, a flag saying the opcode was one it implements, and the context and mux id unchanged.

It covers left shift, logical and arithmetic right shift, sign-extend-word-then-shift-left, and three rotate-then-mask forms. These are: mask from immediates with zero outside the mask, mask from immediates with the merge operand kept outside the mask, and mask derived from the shift amount. One datapath serves both widths. The 32-bit mode narrows the amount and applies its own rule for filling the upper half. The rotate forms build a mask that wraps around when its begin position lies past its end position.

Data moves through a valid/ready pair that holds no storage. The output is valid exactly when the input is valid. The input is ready exactly when the consumer is ready. An operation counts as transferred in a cycle where both valid and ready are high. While ready is low the producer must hold its inputs steady, and the result then stays steady as well.

Top module: `shrot_unit`

## Requirements
- R1: Opcode 0 (shift left) in 32-bit mode shifts the source by the low 6 amount bits. The low 32 result bits are the shifted value truncated to 32 bits, so amounts of 32 to 63 give zero, and the upper 32 bits are zero.
- R2: In 64-bit mode, shifts use all 7 amount bits. Opcode 0 and opcode 1 with the signed flag clear give zero for any amount from 64 to 127.
- R3: Opcode 1 (shift right) in 32-bit mode works on the low 32 source bits with the low 6 amount bits. With the signed flag clear the upper 32 result bits are zero. With it set they are copies of source bit 31, as are the vacated low bits.
- R4: Opcode 1 in 64-bit mode with the signed flag set treats the whole source as signed. Amounts of 64 to 127 give 64 copies of source bit 63.
- R5: Opcode 2 (sign-extend word then shift left) in 64-bit mode sign-extends source bits 31..0 to 64 bits and shifts left by the 7-bit amount. In 32-bit mode it gives the same result as R1.
- R6: For opcodes 3 and 4 the mask begin and end come from the two 6-bit immediates. Bit positions are numbered from the MSB, so position p is result bit 63-p. The begin mask covers positions at or after begin. The end mask covers positions at or before end. The mask is their OR when begin is greater than end, and their AND otherwise.
- R7: For opcode 5 the 7-bit begin is amount plus 32 and the 7-bit end is 63 minus amount, both modulo 128. A begin of 64 or more gives an empty begin mask, and an end of 63 or more gives a full end mask. The R6 combination rule then applies.
- R8: Rotate forms rotate the whole source left by the low 6 amount bits in 64-bit mode, and the low 32 source bits left by the low 5 amount bits in 32-bit mode. The result is (rotated AND mask) OR (other AND NOT mask). Other is the merge operand for opcode 4 and zero for opcodes 3 and 5. In 32-bit mode the upper 32 result bits are zero.
- R9: The result-valid flag is high only when the input is valid and the opcode is 0 to 5. For opcodes 6 and 7 the flag is low and the result is zero.
- R10: The context word and mux id appear on the outputs unchanged in the same cycle.
- R11: Output valid equals input valid and input ready equals output ready in every cycle. A stalled operation keeps its result while the inputs are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation accepted this cycle (follows out_ready) |
| out_valid | output | 1 | Result presented (follows in_valid) |
| out_ready | input | 1 | Consumer takes the result |
| op_code | input | 3 | Operation select, encodings in R1 to R9 |
| op_is32 | input | 1 | 32-bit mode |
| op_signed | input | 1 | Arithmetic right shift select |
| op_mbeg | input | 6 | Mask begin immediate, MSB-zero position |
| op_mend | input | 6 | Mask end immediate, MSB-zero position |
| op_ctx | input | CTX_W | Opaque operation context |
| op_mux | input | MUX_W | Mux id |
| src_a | input | XLEN | Value to shift or rotate |
| amt_b | input | 7 | Shift amount (low bits of the amount operand) |
| merge_c | input | XLEN | Value kept outside the mask for opcode 4 |
| res_data | output | XLEN | Result |
| res_ok | output | 1 | Result valid for a recognised opcode |
| res_ctx | output | CTX_W | Context passed through |
| res_mux | output | MUX_W | Mux id passed through |

## Verification
A stall and an unrecognised opcode can meet in the same cycle. The handshake must then still show a valid output that is not accepted, while the result flag stays low and the data reads zero. The bench holds out_ready low with opcode 6 or 7 and a live input, then judges in_ready, out_valid, res_ok and res_data together. A wrapped mask and the merge operand also meet in one cycle under opcode 4. Table vectors with begin past end, together with random operands compared against an independent mask formula, judge the merged bits on both sides of the wrap.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SHL      = 3'd0,
    OP_SHR      = 3'd1,
    OP_SEXT_SHL = 3'd2,
    OP_ROT_MASK = 3'd3,
    OP_ROT_INS  = 3'd4,
    OP_ROT_AMT  = 3'd5
  } shrot_op_e;
endpackage

// File: rtl/shrot_mask_gen.sv
module shrot_mask_gen #(
  parameter int XLEN  = 64,
  parameter int AMT_W = 7
) (
  input  logic [AMT_W-1:0] pos_beg,
  input  logic [AMT_W-1:0] pos_end,
  output logic [XLEN-1:0]  mask
);
  logic wrap;
  assign wrap = pos_beg > pos_end;

  // position p is MSB-zero, so it drives bit XLEN-1-p
  for (genvar gp = 0; gp < XLEN; gp++) begin : g_pos
    localparam logic [AMT_W-1:0] PV = AMT_W'(gp);
    logic from_beg;
    logic upto_end;
    assign from_beg = PV >= pos_beg;
    assign upto_end = PV <= pos_end;
    assign mask[XLEN-1-gp] = wrap ? (from_beg | upto_end) : (from_beg & upto_end);
  end
endmodule

// File: rtl/shrot_shift.sv
module shrot_shift
  import shrot_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AMT_W = 7
) (
  input  shrot_op_e        op,
  input  logic             is32,
  input  logic             sgn,
  input  logic [XLEN-1:0]  src,
  input  logic [AMT_W-1:0] amt,
  output logic [XLEN-1:0]  res
);
  localparam int HALF  = XLEN / 2;
  localparam int POS_W = AMT_W - 1;

  logic [POS_W-1:0] amt_n;
  logic [HALF-1:0]  lo;
  logic [XLEN-1:0]  shl_n;
  logic [XLEN-1:0]  sext;
  logic [HALF-1:0]  sr_lo;

  assign amt_n = amt[POS_W-1:0];
  assign lo    = src[HALF-1:0];
  assign shl_n = src << amt_n;
  assign sext  = {{HALF{lo[HALF-1]}}, lo};
  assign sr_lo = sgn ? HALF'($signed(lo) >>> amt_n) : (lo >> amt_n);

  always_comb begin
    res = '0;
    unique case (op)
      OP_SHL, OP_SEXT_SHL: begin
        if (is32)               res = {{HALF{1'b0}}, shl_n[HALF-1:0]};
        else if (op == OP_SHL)  res = src << amt;
        else                    res = sext << amt;
      end
      OP_SHR: begin
        if (is32)     res = {{HALF{sgn & lo[HALF-1]}}, sr_lo};
        else if (sgn) res = XLEN'($signed(src) >>> amt);
        else          res = src >> amt;
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/shrot_rotate.sv
module shrot_rotate #(
  parameter int XLEN  = 64,
  parameter int POS_W = 6
) (
  input  logic             is32,
  input  logic             keep_other,
  input  logic [XLEN-1:0]  src,
  input  logic [POS_W-1:0] sh,
  input  logic [XLEN-1:0]  other,
  input  logic [XLEN-1:0]  mask,
  output logic [XLEN-1:0]  res
);
  localparam int HALF = XLEN / 2;

  logic [2*XLEN-1:0] dbl_w;
  logic [XLEN-1:0]   dbl_h;
  logic [XLEN-1:0]   rot;
  logic [XLEN-1:0]   fill;
  logic [XLEN-1:0]   merged;

  assign dbl_w  = {src, src} << sh;
  assign dbl_h  = {src[HALF-1:0], src[HALF-1:0]} << sh[POS_W-2:0];
  assign rot    = is32 ? {{HALF{1'b0}}, dbl_h[XLEN-1:HALF]} : dbl_w[2*XLEN-1:XLEN];
  assign fill   = keep_other ? other : '0;
  assign merged = (rot & mask) | (fill & ~mask);
  assign res    = is32 ? {{HALF{1'b0}}, merged[HALF-1:0]} : merged;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8,
  parameter int MUX_W = 2,
  localparam int POS_W = $clog2(XLEN),
  localparam int AMT_W = POS_W + 1
) (
  input  logic             in_valid,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  input  logic [2:0]       op_code,
  input  logic             op_is32,
  input  logic             op_signed,
  input  logic [POS_W-1:0] op_mbeg,
  input  logic [POS_W-1:0] op_mend,
  input  logic [CTX_W-1:0] op_ctx,
  input  logic [MUX_W-1:0] op_mux,
  input  logic [XLEN-1:0]  src_a,
  input  logic [AMT_W-1:0] amt_b,
  input  logic [XLEN-1:0]  merge_c,
  output logic [XLEN-1:0]  res_data,
  output logic             res_ok,
  output logic [CTX_W-1:0] res_ctx,
  output logic [MUX_W-1:0] res_mux
);
  localparam int HALF = XLEN / 2;

  shrot_op_e        op;
  logic             is_shift;
  logic             is_rot;
  logic             known;
  logic [AMT_W-1:0] beg_pos;
  logic [AMT_W-1:0] end_pos;
  logic [XLEN-1:0]  mask;
  logic [XLEN-1:0]  shift_res;
  logic [XLEN-1:0]  rot_res;

  assign op = shrot_op_e'(op_code);

  always_comb begin
    is_shift = 1'b0;
    is_rot   = 1'b0;
    unique case (op_code)
      3'd0, 3'd1, 3'd2: is_shift = 1'b1;
      3'd3, 3'd4, 3'd5: is_rot   = 1'b1;
      default: ;
    endcase
  end
  assign known = is_shift | is_rot;

  // amount-derived mask bounds wrap modulo 2**AMT_W
  always_comb begin
    if (op == OP_ROT_AMT) begin
      beg_pos = amt_b + AMT_W'(HALF);
      end_pos = AMT_W'(XLEN - 1) - amt_b;
    end else begin
      beg_pos = {1'b0, op_mbeg};
      end_pos = {1'b0, op_mend};
    end
  end

  shrot_mask_gen #(.XLEN(XLEN), .AMT_W(AMT_W)) u_mask (
    .pos_beg (beg_pos),
    .pos_end (end_pos),
    .mask    (mask)
  );

  shrot_shift #(.XLEN(XLEN), .AMT_W(AMT_W)) u_shift (
    .op   (op),
    .is32 (op_is32),
    .sgn  (op_signed),
    .src  (src_a),
    .amt  (amt_b),
    .res  (shift_res)
  );

  shrot_rotate #(.XLEN(XLEN), .POS_W(POS_W)) u_rot (
    .is32       (op_is32),
    .keep_other (op == OP_ROT_INS),
    .src        (src_a),
    .sh         (amt_b[POS_W-1:0]),
    .other      (merge_c),
    .mask       (mask),
    .res        (rot_res)
  );

  assign res_data  = is_shift ? shift_res : (is_rot ? rot_res : '0);
  assign res_ok    = in_valid & known;
  assign res_ctx   = op_ctx;
  assign res_mux   = op_mux;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8,
  parameter int MUX_W = 2,
  localparam int POS_W = $clog2(XLEN),
  localparam int AMT_W = POS_W + 1
) (
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       op_code,
  input logic             op_is32,
  input logic             op_signed,
  input logic [POS_W-1:0] op_mbeg,
  input logic [POS_W-1:0] op_mend,
  input logic [CTX_W-1:0] op_ctx,
  input logic [MUX_W-1:0] op_mux,
  input logic [XLEN-1:0]  src_a,
  input logic [AMT_W-1:0] amt_b,
  input logic [XLEN-1:0]  merge_c,
  input logic [XLEN-1:0]  res_data,
  input logic             res_ok,
  input logic [CTX_W-1:0] res_ctx,
  input logic [MUX_W-1:0] res_mux
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    p_handshake_r11: assert (in_ready == out_ready && out_valid == in_valid);
    p_ok_decode_r9: assert (res_ok == (in_valid && op_code <= 3'd5));
    p_ctx_pass_r10: assert (res_ctx == op_ctx && res_mux == op_mux);
    if (op_code > 3'd5) begin
      p_unknown_zero_r9: assert (res_data == '0);
    end
    if (op_is32 && op_code != 3'd1 && op_code <= 3'd5) begin
      p_upper_zero_r1: assert (res_data[XLEN-1:HALF] == '0);
    end
    if (op_is32 && op_code == 3'd1) begin
      p_upper_fill_r3: assert (res_data[XLEN-1:HALF] == {HALF{op_signed & src_a[HALF-1]}});
    end
    if (!op_is32 && op_code == 3'd0 && amt_b[AMT_W-1]) begin
      p_big_shl_r2: assert (res_data == '0);
    end
    if (!op_is32 && op_code == 3'd1 && op_signed && amt_b[AMT_W-1]) begin
      p_sra_fill_r4: assert (res_data == {XLEN{src_a[XLEN-1]}});
    end
    // position 0 lies outside a non-wrapping mask whose begin is above 0
    if (!op_is32 && op_code == 3'd4 && op_mbeg != '0 && op_mbeg <= op_mend) begin
      p_keep_merge_r8: assert (res_data[XLEN-1] == merge_c[XLEN-1]);
    end
  end
endmodule

bind shrot_unit shrot_unit_chk #(.XLEN(XLEN), .CTX_W(CTX_W), .MUX_W(MUX_W)) u_chk (.*);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic        is32;
    logic        sgn;
    logic [5:0]  mb;
    logic [5:0]  me;
    logic [63:0] src;
    logic [6:0]  amt;
    logic [63:0] mrg;
    logic [63:0] exp;
    logic        ok;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [0:NV-1] = '{
    '{3'd0, 1'b0, 1'b0, 6'd0,  6'd0,  64'h0000_0000_0000_0001, 7'd63,  64'h0, 64'h8000_0000_0000_0000, 1'b1},
    '{3'd0, 1'b0, 1'b0, 6'd0,  6'd0,  64'hFFFF_FFFF_FFFF_FFFF, 7'd64,  64'h0, 64'h0000_0000_0000_0000, 1'b1},
    '{3'd0, 1'b1, 1'b0, 6'd0,  6'd0,  64'hFFFF_FFFF_FFFF_FFFF, 7'd4,   64'h0, 64'h0000_0000_FFFF_FFF0, 1'b1},
    '{3'd1, 1'b1, 1'b0, 6'd0,  6'd0,  64'hFFFF_FFFF_8000_0000, 7'd31,  64'h0, 64'h0000_0000_0000_0001, 1'b1},
    '{3'd1, 1'b1, 1'b1, 6'd0,  6'd0,  64'h0000_0000_8000_0000, 7'd4,   64'h0, 64'hFFFF_FFFF_F800_0000, 1'b1},
    '{3'd1, 1'b0, 1'b1, 6'd0,  6'd0,  64'h8000_0000_0000_0000, 7'd100, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    '{3'd1, 1'b0, 1'b0, 6'd0,  6'd0,  64'h8000_0000_0000_0000, 7'd63,  64'h0, 64'h0000_0000_0000_0001, 1'b1},
    '{3'd2, 1'b0, 1'b0, 6'd0,  6'd0,  64'h0000_0000_8000_0001, 7'd4,   64'h0, 64'hFFFF_FFF8_0000_0010, 1'b1},
    '{3'd2, 1'b1, 1'b0, 6'd0,  6'd0,  64'h0000_0000_8000_0001, 7'd4,   64'h0, 64'h0000_0000_0000_0010, 1'b1},
    '{3'd3, 1'b0, 1'b0, 6'd0,  6'd63, 64'h8000_0000_0000_0001, 7'd1,   64'h0, 64'h0000_0000_0000_0003, 1'b1},
    '{3'd3, 1'b0, 1'b0, 6'd60, 6'd3,  64'hFFFF_FFFF_FFFF_FFFF, 7'd0,   64'h0, 64'hF000_0000_0000_000F, 1'b1},
    '{3'd4, 1'b0, 1'b0, 6'd32, 6'd63, 64'h0000_0000_1234_5678, 7'd4,   64'hAAAA_AAAA_BBBB_BBBB, 64'hAAAA_AAAA_2345_6780, 1'b1},
    '{3'd3, 1'b1, 1'b0, 6'd32, 6'd63, 64'hFFFF_FFFF_8000_0001, 7'd1,   64'h0, 64'h0000_0000_0000_0003, 1'b1},
    '{3'd5, 1'b0, 1'b0, 6'd0,  6'd0,  64'h1234_5678_9ABC_DEF0, 7'd0,   64'h0, 64'h0000_0000_9ABC_DEF0, 1'b1},
    '{3'd5, 1'b0, 1'b0, 6'd0,  6'd0,  64'h1234_5678_9ABC_DEF0, 7'd8,   64'h0, 64'h0000_0000_00DE_F000, 1'b1},
    '{3'd4, 1'b1, 1'b0, 6'd48, 6'd55, 64'h0000_0000_0000_00AB, 7'd8,   64'hFFFF_FFFF_1234_5678, 64'h0000_0000_1234_AB78, 1'b1},
    '{3'd6, 1'b0, 1'b0, 6'd0,  6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 7'd3,   64'h1, 64'h0000_0000_0000_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  op_code;
  logic        op_is32, op_signed;
  logic [5:0]  op_mbeg, op_mend;
  logic [7:0]  op_ctx, res_ctx;
  logic [1:0]  op_mux, res_mux;
  logic [63:0] src_a, merge_c, res_data;
  logic [6:0]  amt_b;
  logic        res_ok;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shrot_unit u_shrot_unit (
    .in_valid (in_valid), .in_ready (in_ready), .out_valid (out_valid), .out_ready (out_ready),
    .op_code (op_code), .op_is32 (op_is32), .op_signed (op_signed),
    .op_mbeg (op_mbeg), .op_mend (op_mend), .op_ctx (op_ctx), .op_mux (op_mux),
    .src_a (src_a), .amt_b (amt_b), .merge_c (merge_c),
    .res_data (res_data), .res_ok (res_ok), .res_ctx (res_ctx), .res_mux (res_mux)
  );

  function automatic string req_of(logic [2:0] op, logic is32, logic sgn);
    case (op)
      3'd0: return is32 ? "R1" : "R2";
      3'd1: return is32 ? "R3" : (sgn ? "R4" : "R2");
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R8";
      3'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  // result model written from the requirements; bit 64 is the valid flag
  function automatic logic [64:0] model(logic [2:0] op, logic is32, logic sgn, logic [5:0] mb,
                                        logic [5:0] me, logic [63:0] src, logic [6:0] amt,
                                        logic [63:0] mrg);
    logic [63:0] r, t, rot, lm, rm, m, oth;
    logic [31:0] lo, rl;
    logic [7:0]  bg, en;
    r  = '0;
    lo = src[31:0];
    case (op)
      3'd0, 3'd2: begin
        t = src << amt[5:0];
        if (is32) r = {32'h0, t[31:0]};
        else if (op == 3'd0) r = src << amt;
        else r = {{32{lo[31]}}, lo} << amt;
      end
      3'd1: begin
        if (is32) begin
          rl = sgn ? 32'($signed(lo) >>> amt[5:0]) : lo >> amt[5:0];
          r = {{32{sgn & lo[31]}}, rl};
        end else r = sgn ? 64'($signed(src) >>> amt) : src >> amt;
      end
      3'd3, 3'd4, 3'd5: begin
        if (op == 3'd5) begin
          bg = {1'b0, amt + 7'd32};
          en = {1'b0, 7'd63 - amt};
        end else begin
          bg = {2'b0, mb};
          en = {2'b0, me};
        end
        lm = (bg >= 8'd64) ? 64'h0 : (~64'h0 >> bg);
        rm = (en >= 8'd63) ? ~64'h0 : ~(~64'h0 >> (en + 8'd1));
        m  = (bg > en) ? (lm | rm) : (lm & rm);
        rot = src;
        rl  = lo;
        for (int k = 0; k < 64; k++) if (k < int'(amt[5:0])) rot = {rot[62:0], rot[63]};
        for (int k = 0; k < 32; k++) if (k < int'(amt[4:0])) rl = {rl[30:0], rl[31]};
        if (is32) rot = {32'h0, rl};
        oth = (op == 3'd4) ? mrg : 64'h0;
        r = (rot & m) | (oth & ~m);
        if (is32) r[63:32] = 32'h0;
      end
      default: r = '0;
    endcase
    return {(op <= 3'd5), r};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic is32, logic sgn, logic [5:0] mb, logic [5:0] me,
                       logic [63:0] src, logic [6:0] amt, logic [63:0] mrg);
    @(negedge clk);
    op_code = op; op_is32 = is32; op_signed = sgn; op_mbeg = mb; op_mend = me;
    src_a = src; amt_b = amt; merge_c = mrg;
    #2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [64:0] mv;
    in_valid = 1'b0; out_ready = 1'b1;
    op_code = '0; op_is32 = 1'b0; op_signed = 1'b0; op_mbeg = '0; op_mend = '0;
    op_ctx = '0; op_mux = '0; src_a = '0; amt_b = '0; merge_c = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle state: nothing presented
    #2;
    check("R11", "idle out_valid", {63'h0, out_valid}, 64'h0);
    check("R9", "idle res_ok", {63'h0, res_ok}, 64'h0);

    in_valid = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].op, TBL[i].is32, TBL[i].sgn, TBL[i].mb, TBL[i].me, TBL[i].src, TBL[i].amt, TBL[i].mrg);
      check(req_of(TBL[i].op, TBL[i].is32, TBL[i].sgn), "table data", res_data, TBL[i].exp);
      check("R9", "table ok", {63'h0, res_ok}, {63'h0, TBL[i].ok});
    end

    // random operands against the model, with context pass-through
    for (int i = 0; i < 400; i++) begin
      op_ctx = 8'($urandom);
      op_mux = 2'($urandom);
      drive(3'($urandom), 1'($urandom), 1'($urandom), 6'($urandom), 6'($urandom),
            {$urandom, $urandom}, 7'($urandom), {$urandom, $urandom});
      mv = model(op_code, op_is32, op_signed, op_mbeg, op_mend, src_a, amt_b, merge_c);
      check(req_of(op_code, op_is32, op_signed), "random data", res_data, mv[63:0]);
      check("R9", "random ok", {63'h0, res_ok}, {63'h0, mv[64]});
      check("R10", "ctx pass", {54'h0, res_mux, res_ctx}, {54'h0, op_mux, op_ctx});
    end

    // R7 boundary: amount 127 wraps begin to 31 and end to 64
    drive(3'd5, 1'b0, 1'b0, 6'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 7'd127, 64'h0);
    check("R7", "amount 127 mask", res_data, 64'h0000_0001_FFFF_FFFF);

    // R11 stall meeting an unrecognised opcode
    out_ready = 1'b0;
    drive(3'd7, 1'b0, 1'b0, 6'd0, 6'd63, 64'h1234, 7'd1, 64'h5678);
    check("R11", "stall in_ready", {63'h0, in_ready}, 64'h0);
    check("R11", "stall out_valid", {63'h0, out_valid}, 64'h1);
    check("R9", "stall unknown ok", {63'h0, res_ok}, 64'h0);
    check("R9", "stall unknown data", res_data, 64'h0);

    // R11 stalled known op keeps its result while held
    drive(3'd0, 1'b0, 1'b0, 6'd0, 6'd0, 64'h1, 7'd8, 64'h0);
    @(negedge clk);
    #2;
    check("R11", "held result", res_data, 64'h100);
    out_ready = 1'b1;
    #1;
    check("R11", "release in_ready", {63'h0, in_ready}, 64'h1);

    // R9 input not valid with a known opcode
    in_valid = 1'b0;
    #1;
    check("R9", "invalid ok low", {63'h0, res_ok}, 64'h0);
    check("R11", "invalid out_valid", {63'h0, out_valid}, 64'h0);

    finish_run();
  end
endmodule